// File: doc/BRIEF.md
# Multichannel converter serial command port

This block is the digital serial front end of an eight-channel, 14-bit converter. It is a serial slave that runs on the serial clock. An active-low chip select frames each exchange. Command bytes arrive on the data input. Each command byte opens with a start bit. The low nibble of the byte then picks one of three actions: begin a conversion, write one channel's input configuration, or load the operating mode.

The block holds a configuration register for each channel. Each register has a differential flag and a three-bit range code. On an accepted conversion request, the selected channel and its configuration go out to the analog front end. The block then captures a 14-bit sample from a parallel port and shifts it out MSB first with an output enable. A one-cycle ready strobe marks the capture.

Two timing modes are available. In the external-acquisition mode, eight more serial clocks of acquisition follow the command byte, and the whole frame is 32 clocks. In the internal-clock mode, the sample is captured as soon as the command byte ends, and the whole frame is 24 clocks.

Top module: `adc_cmd_port`

## Requirements
- R1: After reset every channel is single-ended (flag 0) with range code 000, and the mode is 000. The outputs doutEn, readyStb, selChan, selDiff and selRange are all 0.
- R2: While csN is low and no command is open, zeros on din are skipped. A command byte begins at the first 1 sampled, and that 1 is bit 7 of the byte.
- R3: When a byte is complete, its low nibble decides the action. 0000 is a conversion request and 1000 is a mode load. Any other value is a configuration write. Bits 6..4 are always the channel or mode field.
- R4: A configuration byte {1, chan[2:0], diff, range[2:0]} writes only the addressed channel's register. Here diff=1 means differential.
- R5: A mode byte {1, mode[2:0], 1000} loads the mode from the edge that completes the byte. It is shown on modeOut. Mode 001 selects internal-clock framing, and every other code selects external-acquisition framing.
- R6: A conversion request for an odd channel whose own register is differential is discarded. No capture, no output, no change of selChan, selDiff or selRange. The block waits for a new start bit.
- R7: In external-acquisition mode, the sample is captured on the 16th rising edge of the frame, counting the start bit as edge 1. The frame ends after edge 32.
- R8: In internal-clock mode, the sample is captured on the 8th edge, the last bit of the command, and the frame ends after edge 24.
- R9: From the capture edge, dout gives B13 down to B0 and then two 0 bits, one per clock, with doutEn high for exactly those 16 cycles. doutEn is never high while csN is high.
- R10: readyStb is high for exactly the one cycle after the capture edge.
- R11: Raising csN drops any partial byte or frame in progress, and leaves the configuration and mode registers unchanged.
- R12: An accepted conversion updates selChan, selDiff and selRange on the edge that completes the command byte. They take the channel number and that channel's stored configuration.
- R13: din is ignored from the accepted command until the frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select framing the exchange |
| din | input | 1 | Serial command data, sampled on the rising edge |
| sampleData | input | 14 | Parallel sample from the converter core |
| dout | output | 1 | Serial result bit |
| doutEn | output | 1 | Output enable for dout; low means high impedance |
| readyStb | output | 1 | One-cycle pulse after the sample is captured |
| selChan | output | 3 | Channel of the last accepted conversion |
| selDiff | output | 1 | Differential flag of that channel |
| selRange | output | 3 | Range code of that channel |
| modeOut | output | 3 | Current operating mode code |

## Verification
Configuration, mode and selection outputs are due right after the rising edge that carries bit 0 of a command byte. readyStb and the MSB of the result appear after edge 16 of an external frame or edge 8 of an internal frame. Each later result bit follows one clock after the one before. A behavioural model in the bench advances on the same rising edge as the design. The bench compares every output at the following falling edge, and it changes inputs just after the rising edge, so each comparison falls half a period after the edge where the result is due. Stimulus covers leading zeros, aborted bytes and frames, reserved pairs, both framings, and toggling din during frames.

// File: rtl/adc_cmd_pkg.sv
package adc_cmd_pkg;
  localparam int BYTE_W  = 8;
  localparam int CH_W    = 3;
  localparam int NUM_CH  = 1 << CH_W;
  localparam int RANGE_W = 3;
  localparam logic [3:0] NIB_CONV = 4'b0000;
  localparam logic [3:0] NIB_MODE = 4'b1000;
  localparam logic [CH_W-1:0] MODE_INTCLK = 3'b001;

  typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_ACQ, ST_OUT} ctrlState_e;

  typedef struct packed {
    logic cfgWr;
    logic modeWr;
    logic accept;
    logic latch;
    logic shift;
  } dpCmd_t;
endpackage

// File: rtl/adc_cmd_ctrl.sv
module adc_cmd_ctrl
  import adc_cmd_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int PAD_W    = 2,
  parameter int ACQ_CYC  = 8
) (
  input  logic            sclk,
  input  logic            rstN,
  input  logic            csN,
  input  logic            din,
  input  logic            intClkMode,
  input  logic            rdDiff,
  output logic [CH_W-1:0] cmdChan,
  output logic [3:0]      cmdLow,
  output dpCmd_t          ctl,
  output logic            outActive
);
  localparam int OUT_CYC = SAMPLE_W + PAD_W;
  localparam int CNT_MAX = (OUT_CYC > ACQ_CYC) ? OUT_CYC : ACQ_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX);
  localparam int BODY_W  = BYTE_W - 1;
  localparam int SH_W    = BYTE_W - 2;
  localparam int BIT_W   = $clog2(BODY_W);

  ctrlState_e       state;
  logic [SH_W-1:0]  shiftQ;
  logic [BIT_W-1:0] bitCnt;
  logic [CNT_W-1:0] cnt;
  logic [BODY_W-1:0] body;
  logic byteDone, isConv, isMode, reserved, acceptNow, acqDone, outDone;

  assign body     = {shiftQ, din};
  assign cmdChan  = body[BODY_W-1 -: CH_W];
  assign cmdLow   = body[3:0];
  assign isConv   = (cmdLow == NIB_CONV);
  assign isMode   = (cmdLow == NIB_MODE);
  assign reserved = rdDiff && cmdChan[0];
  assign byteDone = (state == ST_CMD) && (bitCnt == BIT_W'(BODY_W-1)) && !csN;
  assign acceptNow = byteDone && isConv && !reserved;
  assign acqDone  = (state == ST_ACQ) && (cnt == CNT_W'(ACQ_CYC-1)) && !csN;
  assign outDone  = (state == ST_OUT) && (cnt == CNT_W'(OUT_CYC-1));
  assign outActive = (state == ST_OUT) && !csN;

  always_comb begin
    ctl        = '0;
    ctl.cfgWr  = byteDone && !isConv && !isMode;
    ctl.modeWr = byteDone && isMode;
    ctl.accept = acceptNow;
    ctl.latch  = (acceptNow && intClkMode) || acqDone;
    ctl.shift  = outActive;
  end

  always_ff @(posedge sclk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      shiftQ <= '0;
      bitCnt <= '0;
      cnt    <= '0;
    end else if (csN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      cnt    <= '0;
    end else begin
      case (state)
        ST_IDLE: if (din) begin
          state  <= ST_CMD;
          bitCnt <= '0;
        end
        ST_CMD: begin
          shiftQ <= {shiftQ[SH_W-2:0], din};
          bitCnt <= bitCnt + 1'b1;
          if (byteDone) begin
            bitCnt <= '0;
            cnt    <= '0;
            if (acceptNow) state <= intClkMode ? ST_OUT : ST_ACQ;
            else           state <= ST_IDLE;
          end
        end
        ST_ACQ: begin
          cnt <= cnt + 1'b1;
          if (acqDone) begin
            state <= ST_OUT;
            cnt   <= '0;
          end
        end
        ST_OUT: begin
          cnt <= cnt + 1'b1;
          if (outDone) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: a reserved differential pair code leaves the block waiting for a start bit
  a_r6_reserved_dropped: assert property (@(posedge sclk) disable iff (!rstN)
    (byteDone && isConv && reserved) |=> (state == ST_IDLE));

  // R11: chip select high returns the sequencer to idle
  a_r11_abort_idle: assert property (@(posedge sclk) disable iff (!rstN)
    csN |=> (state == ST_IDLE));

  // R9: after the last padded bit the output phase is over
  a_r9_frame_closes: assert property (@(posedge sclk) disable iff (!rstN)
    (outDone && !csN) |=> !outActive);
endmodule

// File: rtl/adc_cmd_dpath.sv
module adc_cmd_dpath
  import adc_cmd_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int PAD_W    = 2
) (
  input  logic               sclk,
  input  logic               rstN,
  input  dpCmd_t             ctl,
  input  logic [CH_W-1:0]    cmdChan,
  input  logic [3:0]         cmdLow,
  input  logic [SAMPLE_W-1:0] sampleData,
  output logic               rdDiff,
  output logic               intClkMode,
  output logic [CH_W-1:0]    modeOut,
  output logic [CH_W-1:0]    selChan,
  output logic               selDiff,
  output logic [RANGE_W-1:0] selRange,
  output logic               dout,
  output logic               readyStb
);
  localparam int OUT_W = SAMPLE_W + PAD_W;

  logic [NUM_CH-1:0]              cfgDiff;
  logic [NUM_CH-1:0][RANGE_W-1:0] cfgRange;
  logic [CH_W-1:0]                modeReg;
  logic [OUT_W-1:0]               resQ;

  assign rdDiff     = cfgDiff[cmdChan];
  assign intClkMode = (modeReg == MODE_INTCLK);
  assign modeOut    = modeReg;
  assign dout       = resQ[OUT_W-1];

  always_ff @(posedge sclk or negedge rstN) begin
    if (!rstN) begin
      cfgDiff  <= '0;
      cfgRange <= '0;
    end else if (ctl.cfgWr) begin
      cfgDiff[cmdChan]  <= cmdLow[3];
      cfgRange[cmdChan] <= cmdLow[RANGE_W-1:0];
    end
  end

  always_ff @(posedge sclk or negedge rstN) begin
    if (!rstN)           modeReg <= '0;
    else if (ctl.modeWr) modeReg <= cmdChan;
  end

  always_ff @(posedge sclk or negedge rstN) begin
    if (!rstN) begin
      selChan  <= '0;
      selDiff  <= 1'b0;
      selRange <= '0;
    end else if (ctl.accept) begin
      selChan  <= cmdChan;
      selDiff  <= cfgDiff[cmdChan];
      selRange <= cfgRange[cmdChan];
    end
  end

  always_ff @(posedge sclk or negedge rstN) begin
    if (!rstN) begin
      resQ     <= '0;
      readyStb <= 1'b0;
    end else begin
      readyStb <= ctl.latch;
      if (ctl.latch)      resQ <= {sampleData, {PAD_W{1'b0}}};
      else if (ctl.shift) resQ <= {resQ[OUT_W-2:0], 1'b0};
    end
  end

  // R3: at most one decoded action per completed byte
  a_r3_one_action: assert property (@(posedge sclk) disable iff (!rstN)
    $onehot0({ctl.cfgWr, ctl.modeWr, ctl.accept}));

  // R4: channel configuration moves only on a configuration write
  a_r4_cfg_hold: assert property (@(posedge sclk) disable iff (!rstN)
    !ctl.cfgWr |=> ($stable(cfgDiff) && $stable(cfgRange)));

  // R5: the mode register moves only on a mode load
  a_r5_mode_hold: assert property (@(posedge sclk) disable iff (!rstN)
    !ctl.modeWr |=> $stable(modeReg));

  // R10: the ready pulse never lasts two cycles
  a_r10_ready_single: assert property (@(posedge sclk) disable iff (!rstN)
    readyStb |=> !readyStb);

  // R12: selection outputs hold between accepted conversions
  a_r12_sel_hold: assert property (@(posedge sclk) disable iff (!rstN)
    !ctl.accept |=> ($stable(selChan) && $stable(selDiff) && $stable(selRange)));
endmodule

// File: rtl/adc_cmd_port.sv
module adc_cmd_port
  import adc_cmd_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int PAD_W    = 2,
  parameter int ACQ_CYC  = 8
) (
  input  logic                sclk,
  input  logic                rstN,
  input  logic                csN,
  input  logic                din,
  input  logic [SAMPLE_W-1:0] sampleData,
  output logic                dout,
  output logic                doutEn,
  output logic                readyStb,
  output logic [CH_W-1:0]     selChan,
  output logic                selDiff,
  output logic [RANGE_W-1:0]  selRange,
  output logic [CH_W-1:0]     modeOut
);
  dpCmd_t          ctl;
  logic [CH_W-1:0] cmdChan;
  logic [3:0]      cmdLow;
  logic            rdDiff, intClkMode, outActive;

  adc_cmd_ctrl #(.SAMPLE_W(SAMPLE_W), .PAD_W(PAD_W), .ACQ_CYC(ACQ_CYC)) ctrl_i (
    .sclk(sclk), .rstN(rstN), .csN(csN), .din(din),
    .intClkMode(intClkMode), .rdDiff(rdDiff),
    .cmdChan(cmdChan), .cmdLow(cmdLow), .ctl(ctl), .outActive(outActive)
  );

  adc_cmd_dpath #(.SAMPLE_W(SAMPLE_W), .PAD_W(PAD_W)) dpath_i (
    .sclk(sclk), .rstN(rstN), .ctl(ctl), .cmdChan(cmdChan), .cmdLow(cmdLow),
    .sampleData(sampleData), .rdDiff(rdDiff), .intClkMode(intClkMode),
    .modeOut(modeOut), .selChan(selChan), .selDiff(selDiff), .selRange(selRange),
    .dout(dout), .readyStb(readyStb)
  );

  assign doutEn = outActive;
endmodule

// File: tb/adc_cmd_port_tb_top.sv
module adc_cmd_port_tb_top;
  localparam int CLK_PERIOD = 10;

  logic sclk = 1'b0, rstN = 1'b0, csN = 1'b1, din = 1'b0;
  logic [13:0] sampleData = '0;
  logic dout, doutEn, readyStb, selDiff;
  logic [2:0] selChan, selRange, modeOut;

  int nChecks = 0, nFails = 0;
  bit finished = 0;
  string curTag = "R1";

  // behavioural reference state
  int ph = 0, nb = 0, bv = 0, cnt = 0, sh = 0;
  int mMode = 0, mSelC = 0, mSelD = 0, mSelR = 0, mRdy = 0;
  int cfgD[8], cfgR[8];

  always #(CLK_PERIOD/2) sclk = ~sclk;

  adc_cmd_port dut_i (
    .sclk(sclk), .rstN(rstN), .csN(csN), .din(din), .sampleData(sampleData),
    .dout(dout), .doutEn(doutEn), .readyStb(readyStb), .selChan(selChan),
    .selDiff(selDiff), .selRange(selRange), .modeOut(modeOut)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s (%s) actual %0d expected %0d at %0t", req, curTag, act, exp, $time);
    end
  endtask

  always @(posedge sclk or negedge rstN) begin
    if (!rstN) begin
      ph = 0; mMode = 0; mSelC = 0; mSelD = 0; mSelR = 0; mRdy = 0; sh = 0;
      for (int i = 0; i < 8; i++) begin cfgD[i] = 0; cfgR[i] = 0; end
    end else if (csN) begin
      ph = 0; mRdy = 0;
    end else begin
      mRdy = 0;
      case (ph)
        0: if (din) begin ph = 1; nb = 0; bv = 1; end
        1: begin
          bv = bv * 2 + int'(din); nb++;
          if (nb == 7) begin
            int lo, c;
            lo = bv & 15; c = (bv >> 4) & 7; ph = 0;
            if (lo == 0) begin
              if (!(cfgD[c] == 1 && (c % 2) == 1)) begin
                mSelC = c; mSelD = cfgD[c]; mSelR = cfgR[c]; cnt = 0;
                if (mMode == 1) begin sh = int'(sampleData) << 2; mRdy = 1; ph = 3; end
                else ph = 2;
              end
            end else if (lo == 8) mMode = c;
            else begin cfgD[c] = lo >> 3; cfgR[c] = lo & 7; end
          end
        end
        2: begin
          cnt++;
          if (cnt == 8) begin sh = int'(sampleData) << 2; mRdy = 1; ph = 3; cnt = 0; end
        end
        3: begin
          sh = (sh << 1) & 16'hFFFF; cnt++;
          if (cnt == 16) ph = 0;
        end
        default: ph = 0;
      endcase
    end
  end

  // compare every output half a period after each rising edge
  always @(negedge sclk) if (rstN && !finished) begin
    int expEn;
    expEn = (ph == 3 && !csN) ? 1 : 0;
    chk(int'(doutEn) == expEn, "R9 enable", int'(doutEn), expEn);
    if (expEn == 1) chk(int'(dout) == ((sh >> 15) & 1), "R9 data bit", int'(dout), (sh >> 15) & 1);
    chk(int'(readyStb) == mRdy, "R10 ready", int'(readyStb), mRdy);
    chk(int'(selChan) == mSelC, "R12 channel", int'(selChan), mSelC);
    chk(int'(selDiff) == mSelD, "R12 diff", int'(selDiff), mSelD);
    chk(int'(selRange) == mSelR, "R12 range", int'(selRange), mSelR);
    chk(int'(modeOut) == mMode, "R5 mode", int'(modeOut), mMode);
  end

  task automatic tick(input logic c, input logic d);
    @(posedge sclk); #1; csN = c; din = d;
  endtask

  task automatic sendByte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) tick(1'b0, b[i]);
  endtask

  task automatic hold(input int n, input bit toggle);
    for (int i = 0; i < n; i++) tick(1'b0, toggle ? logic'(i[0]) : 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge sclk);
    rstN = 1'b1;
    #1;
    // R1 reset state at the ports
    chk(doutEn == 1'b0, "R1 doutEn", int'(doutEn), 0);
    chk(readyStb == 1'b0, "R1 ready", int'(readyStb), 0);
    chk(modeOut == 3'd0, "R1 mode", int'(modeOut), 0);
    chk(selChan == 3'd0 && selDiff == 1'b0 && selRange == 3'd0, "R1 selection", int'(selRange), 0);

    curTag = "R2 leading zeros, R7 external frame";
    hold(3, 0);
    sampleData = 14'h2A5C;
    sendByte(8'b1_011_0000); hold(24, 0); tick(1, 0);

    curTag = "R4 per-channel configuration";
    sendByte(8'b1_101_0_101); tick(1, 0);
    sendByte(8'b1_010_1_011); tick(1, 0);
    sampleData = 14'h1F03;
    sendByte(8'b1_101_0000); hold(24, 0); tick(1, 0);
    sendByte(8'b1_011_0000); hold(24, 0); tick(1, 0);

    curTag = "R6 reserved pair";
    sendByte(8'b1_011_1_010); tick(1, 0);
    sendByte(8'b1_011_0000); hold(24, 0); tick(1, 0);
    sendByte(8'b1_010_0000); hold(24, 0); tick(1, 0);

    curTag = "R8 internal frame";
    sendByte(8'b1_001_1000);
    sampleData = 14'h3FFF;
    sendByte(8'b1_100_0000); hold(16, 0); tick(1, 0);

    curTag = "R13 din toggling in frame";
    sampleData = 14'h1234;
    sendByte(8'b1_110_0000); hold(16, 1); tick(1, 0);

    curTag = "R3 nibble priority";
    sendByte(8'b1_000_1000);
    sampleData = 14'h0001;
    sendByte(8'b1_111_0000); hold(24, 1); tick(1, 0);

    curTag = "R11 abort";
    tick(0, 1); tick(0, 1); tick(0, 0); tick(0, 1); tick(1, 0); tick(1, 0);
    sendByte(8'b1_101_0000); hold(12, 0); tick(1, 0); tick(1, 0);
    sampleData = 14'h2001;
    sendByte(8'b1_101_0000); hold(20, 0); tick(1, 0); tick(1, 0);
    sendByte(8'b1_000_0000); hold(24, 0); tick(1, 0); tick(1, 0);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge sclk);
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog (%s) actual %0d expected %0d", curTag, 0, 1);
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule